// File: doc/BRIEF.md
# Railway Cutout Window Sequencer

This block drives the enable and cutout controls of a track power stage through the quiet gap after a command packet. An upstream decoder gives a one-cycle trigger when it sees the packet end bit. The trigger starts a timer that counts whole microseconds. The sequencer then moves the two controls through a fixed break-before-make order and hands the track back to normal drive:

1. Enable is dropped.
2. There is a short dead gap.
3. The cutout control is asserted for most of the gap.
4. The cutout control is released, followed by a second dead gap.
5. Enable is restored.

A static feature input selects cutout operation. When it is low, the block stops sequencing and holds both controls asserted. The time points are parameters in microseconds. The timer prescaler is derived from a clock-frequency parameter, so one timer count is one microsecond.

The controller has six states:

- `ST_IDLE`: enable on, cutout off.
- `ST_EN_HOLD`: enable still on after the trigger.
- `ST_GAP_PRE`: both controls off.
- `ST_CUT`: cutout on.
- `ST_GAP_POST`: both controls off again.
- `ST_BYPASS`: both controls forced on.

The transitions are:

- start: `ST_IDLE` to `ST_EN_HOLD` when a trigger arrives with the feature on.
- drop: `ST_EN_HOLD` to `ST_GAP_PRE` at 26 µs.
- make: `ST_GAP_PRE` to `ST_CUT` at 30 µs.
- break: `ST_CUT` to `ST_GAP_POST` at 484 µs.
- restore: `ST_GAP_POST` to `ST_IDLE` at 488 µs.
- abort: any state to `ST_BYPASS` when the feature input is low.
- resume: `ST_BYPASS` to `ST_IDLE` once the feature input is high again.

Top module: `cutout_window_seq`

## Requirements
- R1: During reset and after its release (feature on, no trigger), `trk_en`=1, `trk_cut`=0, `seq_busy`=0 and `seq_done`=0.
- R2: While `cutout_mode` is low, both outputs read 1 from the next clock edge onward, `seq_busy` stays 0, and triggers are ignored. When the input returns high, the next edge gives the idle outputs (1, 0, 0, 0).
- R3: If `cutout_mode` falls during a sequence, the next edge gives `trk_en`=1, `trk_cut`=1 and `seq_busy`=0, with no `seq_done` pulse.
- R4: A trigger sampled at edge k while idle, with the feature on, sets `seq_busy` at that edge. `trk_en` stays 1 until edge k+26·P, where P is the number of clocks per microsecond.
- R5: From edge k+26·P up to edge k+30·P, `trk_en`=0 and `trk_cut`=0.
- R6: From edge k+30·P up to edge k+484·P, `trk_cut`=1 and `trk_en`=0.
- R7: From edge k+484·P up to edge k+488·P, `trk_cut`=0 and `trk_en`=0.
- R8: At edge k+488·P, `trk_en` returns to 1 and `seq_busy` falls. `seq_done` is 1 for exactly that one cycle.
- R9: Triggers that arrive while `seq_busy` is 1 do not restart or shift the sequence.
- R10: P equals `CLK_HZ`/1,000,000, and all four time points scale with it.
- R11: While `seq_busy` is 1, `trk_en` and `trk_cut` are never both 1.
- R12: A trigger sampled on the first idle edge after `seq_done` starts a new sequence at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cutout_mode | input | 1 | 1 = cutout sequencing enabled, 0 = bypass with both controls on |
| pkt_end | input | 1 | One-cycle trigger at the packet end bit |
| trk_en | output | 1 | Power-stage enable control |
| trk_cut | output | 1 | Cutout control |
| seq_busy | output | 1 | High from the trigger until the enable is restored |
| seq_done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Each sequence is compared on every cycle against a window model that takes the cycle offset from the trigger. The model runs the clock at four cycles per microsecond, so the scaled boundaries are hit exactly.

Several kinds of run are used:

- A clean directed sequence pins the four window edges and the done pulse.
- Runs with random extra triggers scattered through the sequence separate a design that ignores retriggers from one that restarts or shifts its windows.
- A trigger placed on the first idle cycle after completion shows that back-to-back sequences are possible.
- Random triggers while bypassed, and a feature drop at a random point inside a running sequence, show that bypass overrides both idle and active states and gives no done pulse.

// File: rtl/cutout_pkg.sv
package cutout_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_EN_HOLD  = 3'd1,
        ST_GAP_PRE  = 3'd2,
        ST_CUT      = 3'd3,
        ST_GAP_POST = 3'd4,
        ST_BYPASS   = 3'd5
    } seq_state_t;

    localparam int N_EDGES      = 4;
    localparam int EDGE_EN_OFF  = 0;
    localparam int EDGE_CUT_ON  = 1;
    localparam int EDGE_CUT_OFF = 2;
    localparam int EDGE_EN_ON   = 3;

endpackage

// File: rtl/cutout_us_timer.sv
module cutout_us_timer #(
    parameter int TICKS_PER_US = 125,
    parameter int US_LIMIT     = 488,
    parameter int US_W         = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    output logic [US_W-1:0] us_cnt,
    output logic            us_tick
);

    localparam int PRE_W = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_US - 1);

    logic [PRE_W-1:0] pre_q;

    assign us_tick = run && !clr && (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            us_cnt <= '0;
        end else if (clr) begin
            pre_q  <= '0;
            us_cnt <= '0;
        end else if (run) begin
            if (us_tick) begin
                pre_q  <= '0;
                us_cnt <= us_cnt + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    AST_US_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        us_cnt <= US_W'(US_LIMIT)); // R10

    AST_US_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |=> (us_cnt == $past(us_cnt)) || (us_cnt == $past(us_cnt) + 1'b1)); // R10

endmodule

// File: rtl/cutout_edge_cmp.sv
module cutout_edge_cmp #(
    parameter int                  N       = 4,
    parameter int                  US_W    = 9,
    parameter logic [N*US_W-1:0]   THR_VEC = '1
) (
    input  logic            us_tick,
    input  logic [US_W-1:0] us_cnt,
    output logic [N-1:0]    hit
);

    for (genvar i = 0; i < N; i++) begin : g_edge
        localparam logic [US_W-1:0] THR_M1 = US_W'(THR_VEC[i*US_W +: US_W] - 1);
        assign hit[i] = us_tick && (us_cnt == THR_M1);
    end

endmodule

// File: rtl/cutout_seq_fsm.sv
module cutout_seq_fsm
    import cutout_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en,
    input  logic               trig,
    input  logic [N_EDGES-1:0] hit,
    output logic               tmr_clr,
    output logic               tmr_run,
    output logic               en_q,
    output logic               cut_q,
    output logic               busy_q,
    output logic               done_q
);

    seq_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        if (!mode_en) begin
            state_nx = ST_BYPASS;
        end else begin
            unique case (state_q)
                ST_IDLE:     if (trig)              state_nx = ST_EN_HOLD;
                ST_EN_HOLD:  if (hit[EDGE_EN_OFF])  state_nx = ST_GAP_PRE;
                ST_GAP_PRE:  if (hit[EDGE_CUT_ON])  state_nx = ST_CUT;
                ST_CUT:      if (hit[EDGE_CUT_OFF]) state_nx = ST_GAP_POST;
                ST_GAP_POST: if (hit[EDGE_EN_ON])   state_nx = ST_IDLE;
                ST_BYPASS:                          state_nx = ST_IDLE;
                default:                            state_nx = ST_IDLE;
            endcase
        end
    end

    assign tmr_clr = (state_q == ST_IDLE) && (state_nx == ST_EN_HOLD);
    assign tmr_run = (state_q == ST_EN_HOLD) || (state_q == ST_GAP_PRE) ||
                     (state_q == ST_CUT)     || (state_q == ST_GAP_POST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b1;
            cut_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q == ST_GAP_POST) && (state_nx == ST_IDLE);
            unique case (state_nx)
                ST_IDLE:     begin en_q <= 1'b1; cut_q <= 1'b0; busy_q <= 1'b0; end
                ST_EN_HOLD:  begin en_q <= 1'b1; cut_q <= 1'b0; busy_q <= 1'b1; end
                ST_GAP_PRE:  begin en_q <= 1'b0; cut_q <= 1'b0; busy_q <= 1'b1; end
                ST_CUT:      begin en_q <= 1'b0; cut_q <= 1'b1; busy_q <= 1'b1; end
                ST_GAP_POST: begin en_q <= 1'b0; cut_q <= 1'b0; busy_q <= 1'b1; end
                ST_BYPASS:   begin en_q <= 1'b1; cut_q <= 1'b1; busy_q <= 1'b0; end
                default:     begin en_q <= 1'b1; cut_q <= 1'b0; busy_q <= 1'b0; end
            endcase
        end
    end

    AST_BYPASS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> (en_q && cut_q && !busy_q)); // R2

    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !mode_en) |=> (!busy_q && !done_q)); // R3

    AST_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !(en_q && cut_q)); // R11

    AST_CUT_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cut_q) && busy_q) |-> ($past(!en_q) && !en_q)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R8

    AST_DONE_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (en_q && !cut_q && !busy_q && $past(busy_q))); // R8

endmodule

// File: rtl/cutout_window_seq.sv
module cutout_window_seq #(
    parameter int CLK_HZ       = 125_000_000,
    parameter int T_EN_OFF_US  = 26,
    parameter int T_CUT_ON_US  = 30,
    parameter int T_CUT_OFF_US = 484,
    parameter int T_EN_ON_US   = 488
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cutout_mode,
    input  logic pkt_end,
    output logic trk_en,
    output logic trk_cut,
    output logic seq_busy,
    output logic seq_done
);

    import cutout_pkg::*;

    localparam int TICKS_PER_US = CLK_HZ / 1_000_000;
    localparam int US_W         = $clog2(T_EN_ON_US + 1);
    localparam logic [N_EDGES*US_W-1:0] THR_VEC = {
        US_W'(T_EN_ON_US), US_W'(T_CUT_OFF_US), US_W'(T_CUT_ON_US), US_W'(T_EN_OFF_US)
    };

    logic [US_W-1:0]    us_cnt;
    logic               us_tick;
    logic [N_EDGES-1:0] hit;
    logic               tmr_clr;
    logic               tmr_run;

    cutout_us_timer #(
        .TICKS_PER_US (TICKS_PER_US),
        .US_LIMIT     (T_EN_ON_US),
        .US_W         (US_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .us_cnt  (us_cnt),
        .us_tick (us_tick)
    );

    cutout_edge_cmp #(
        .N       (N_EDGES),
        .US_W    (US_W),
        .THR_VEC (THR_VEC)
    ) u_cmp (
        .us_tick (us_tick),
        .us_cnt  (us_cnt),
        .hit     (hit)
    );

    cutout_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_en (cutout_mode),
        .trig    (pkt_end),
        .hit     (hit),
        .tmr_clr (tmr_clr),
        .tmr_run (tmr_run),
        .en_q    (trk_en),
        .cut_q   (trk_cut),
        .busy_q  (seq_busy),
        .done_q  (seq_done)
    );

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && $past(seq_busy)) |-> (us_cnt >= $past(us_cnt))); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_busy) |-> (us_cnt == '0)); // R4

endmodule

// File: tb/sim_cutout_window_seq.sv
module sim_cutout_window_seq;

    localparam int CLK_HZ = 4_000_000;
    localparam int TPU    = CLK_HZ / 1_000_000;
    localparam int E_OFF  = 26 * TPU;
    localparam int C_ON   = 30 * TPU;
    localparam int C_OFF  = 484 * TPU;
    localparam int E_ON   = 488 * TPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b1;
    logic trig = 1'b0;
    logic en, cut, busy, done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cutout_window_seq #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .cutout_mode(mode), .pkt_end(trig),
        .trk_en(en), .trk_cut(cut), .seq_busy(busy), .seq_done(done)
    );

    function automatic logic [3:0] exp_at(int j);
        logic e, c, b, d;
        e = !(j >= E_OFF && j < E_ON);
        c = (j >= C_ON && j < C_OFF);
        b = (j < E_ON);
        d = (j == E_ON);
        return {e, c, b, d};
    endfunction

    function automatic string win_tag(int j);
        if (j == E_OFF - 1 || j == E_OFF) return "R10";
        if (j < E_OFF)  return "R4";
        if (j < C_ON)   return "R5";
        if (j < C_OFF)  return "R6";
        if (j < E_ON)   return "R7";
        return "R8";
    endfunction

    task automatic chk(string req, logic [3:0] exp);
        n_chk++;
        if ({en, cut, busy, done} !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t actual{en,cut,busy,done}=%b expected=%b",
                     req, $time, {en, cut, busy, done}, exp);
        end
    endtask

    task automatic chk_r11();
        n_chk++;
        if (busy && en && cut) begin
            n_fail++;
            $display("FAIL R11 t=%0t actual en&cut=1 expected 0 while busy", $time);
        end
    endtask

    // Entry: the start edge has just passed (offset j=0 is sampled now).
    task automatic run_seq(bit retrig, bit chain, bit chained_in);
        for (int j = 0; j <= E_ON; j++) begin
            if (chained_in && j == 0) chk("R12", exp_at(j));
            else if (retrig)          chk({"R9 ", win_tag(j)}, exp_at(j));
            else                      chk(win_tag(j), exp_at(j));
            chk_r11();
            if (j == E_ON) trig = chain;
            else           trig = retrig && ($urandom_range(0, 7) == 0);
            @(negedge clk);
        end
        if (!chain) chk("R8", 4'b1000);
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int abort_at;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        chk("R1", 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 4'b1000);
        @(negedge clk);
        chk("R1", 4'b1000);

        // directed clean sequence
        trig = 1'b1;
        @(negedge clk);
        run_seq(1'b0, 1'b0, 1'b0);

        // random retriggers, then back-to-back chained sequence
        trig = 1'b1;
        @(negedge clk);
        run_seq(1'b1, 1'b1, 1'b0);
        run_seq(1'b1, 1'b0, 1'b1);

        // bypass while idle with random triggers
        mode = 1'b0;
        @(negedge clk);
        chk("R2", 4'b1100);
        for (int i = 0; i < 24; i++) begin
            trig = ($urandom_range(0, 1) == 1);
            @(negedge clk);
            chk("R2", 4'b1100);
        end
        trig = 1'b0;
        mode = 1'b1;
        @(negedge clk);
        chk("R2", 4'b1000);

        // abort at a random point inside a running sequence
        for (int r = 0; r < 2; r++) begin
            abort_at = $urandom_range(1, E_ON - 1);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            repeat (abort_at) @(negedge clk);
            chk("R3", exp_at(abort_at));
            mode = 1'b0;
            @(negedge clk);
            chk("R3", 4'b1100);
            @(negedge clk);
            chk("R3", 4'b1100);
            mode = 1'b1;
            @(negedge clk);
            chk("R3", 4'b1000);
        end

        // a further random sequence after an abort
        trig = 1'b1;
        @(negedge clk);
        run_seq(1'b1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule